// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit forms a linear address from a segment register value and an offset. A mode input picks one of two rules. In real mode the segment value is multiplied by sixteen and added to a 16-bit offset. In protected mode the segment value is a selector. The selector names an entry in one of two small on-chip descriptor tables, one global and one local. The offset is compared with that entry's limit, and the entry's base is added to it.

Descriptor entries are written through a dedicated write port, so a lookup never has to walk memory. Requests arrive with a valid/ready handshake. One cycle later the response appears on registered outputs: the address, an address-ok flag, a fault flag, a cause code and the requested privilege bits of the selector.

Top module: `seg_xlate`

## Requirements
- R1: In real mode (`req_prot`=0) the result is the 20-bit sum `{req_seg,4'h0} + req_off[15:0]`. The sum wraps modulo 2^20, bits 31:20 of `rsp_addr` are zero, `req_off[31:16]` has no effect, no fault is raised and `rsp_rpl` is 0.
- R2: In protected mode the selector decodes as follows. Bits [15:3] are the descriptor index. Bit 2 set picks the local table and clear picks the global table. Bits [1:0] appear on `rsp_rpl`.
- R3: A protected request whose selector has index 0 and bit 2 clear faults with cause 1 (null selector). Index 0 of the local table is an ordinary usable entry.
- R4: A protected request whose index is DESC_PER_TABLE or greater faults with cause 2 (index outside the table).
- R5: When the granularity bit of an entry is 0, the effective limit is the 20-bit limit itself. An offset equal to the limit passes, and an offset one greater faults with cause 3.
- R6: When the granularity bit is 1, the effective limit is `{limit,12'hFFF}`. An offset above it faults with cause 3.
- R7: A protected request without a fault returns `base + offset` modulo 2^32, with `rsp_ok`=1 and `rsp_fault`=0. On any fault `rsp_ok`=0 and `rsp_addr`=0. Cause 0 means no fault.
- R8: `rsp_valid` is high for exactly the one cycle after each accepted request (`req_valid` and `req_ready`). At all other times it is low.
- R9: A descriptor write takes effect for requests accepted in later cycles. A request accepted in the same cycle as a write sees the old entry. The two tables are separate storage.
- R10: While reset is held, `req_ready` and `rsp_valid` are 0, and all descriptor entries clear to base 0, limit 0 and granularity 0. `req_ready` rises in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Descriptor write strobe |
| wr_local | input | 1 | Write target: 1 local table, 0 global table |
| wr_idx | input | IDX_W | Entry index to write |
| wr_base | input | 32 | Segment base |
| wr_limit | input | 20 | Segment limit (last valid offset, before scaling) |
| wr_gran | input | 1 | Granularity: 1 scales the limit by 4 KB |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit accepts requests |
| req_prot | input | 1 | 1 protected mode, 0 real mode |
| req_seg | input | 16 | Segment value or selector |
| req_off | input | 32 | Offset |
| rsp_valid | output | 1 | Response present |
| rsp_addr | output | 32 | Linear address, 0 on fault |
| rsp_ok | output | 1 | Address usable |
| rsp_fault | output | 1 | Fault raised |
| rsp_cause | output | 2 | 0 none, 1 null selector, 2 index out of range, 3 limit |
| rsp_rpl | output | 2 | Requested privilege bits of the selector |

## Verification
The bench probes the limit boundaries of both granularities: an offset exactly at the limit must pass and one beyond it must fail. A design that used `<` instead of `<=`, or that shifted the limit without filling the low twelve bits, would fail one of these two cases. Real-mode tests wrap past 1 MB and put junk in the upper offset bits, which catches a design that kept a 21-bit sum or used the full offset. Selector tests cover a global index 0 with nonzero privilege bits, a local index 0 that is legal, an index just past the table, and a write issued in the same cycle as a request. A design that decoded the null case on the whole selector, ignored the table bit, or forwarded fresh write data would give the wrong fault or base in these tests.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int DESC_PER_TABLE = 8,
  parameter int IDX_W = (DESC_PER_TABLE > 1) ? $clog2(DESC_PER_TABLE) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_local,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_base,
  input  logic [19:0]      wr_limit,
  input  logic             wr_gran,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_prot,
  input  logic [15:0]      req_seg,
  input  logic [31:0]      req_off,
  output logic             rsp_valid,
  output logic [31:0]      rsp_addr,
  output logic             rsp_ok,
  output logic             rsp_fault,
  output logic [1:0]       rsp_cause,
  output logic [1:0]       rsp_rpl
);
  localparam int ENTRIES = 2 * DESC_PER_TABLE;
  localparam int ENT_W = $clog2(ENTRIES);
  localparam logic [1:0] C_NONE = 2'd0, C_NULL = 2'd1, C_RANGE = 2'd2, C_LIMIT = 2'd3;

  logic [31:0] base_q [ENTRIES];
  logic [19:0] lim_q  [ENTRIES];
  logic        gran_q [ENTRIES];

  wire [ENT_W-1:0] wr_ent = ENT_W'(wr_idx) + (wr_local ? ENT_W'(DESC_PER_TABLE) : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        base_q[i] <= '0;
        lim_q[i]  <= '0;
        gran_q[i] <= 1'b0;
      end
    end else if (wr_en && (int'(wr_idx) < DESC_PER_TABLE)) begin
      base_q[wr_ent] <= wr_base;
      lim_q[wr_ent]  <= wr_limit;
      gran_q[wr_ent] <= wr_gran;
    end
  end

  wire [12:0] sel_idx  = req_seg[15:3];
  wire        sel_loc  = req_seg[2];
  wire        in_range = sel_idx < 13'(DESC_PER_TABLE);
  wire        is_null  = (sel_idx == 13'd0) && !sel_loc;
  wire [ENT_W-1:0] rd_ent = in_range ?
      (ENT_W'(sel_idx) + (sel_loc ? ENT_W'(DESC_PER_TABLE) : '0)) : '0;

  wire [31:0] d_base  = base_q[rd_ent];
  wire [19:0] d_lim   = lim_q[rd_ent];
  wire        d_gran  = gran_q[rd_ent];
  wire [31:0] eff_lim = d_gran ? {d_lim, 12'hFFF} : {12'h000, d_lim};
  wire        over    = req_off > eff_lim;

  wire [19:0] real_sum = {req_seg, 4'h0} + {4'h0, req_off[15:0]};
  wire [31:0] prot_sum = d_base + req_off;

  logic [1:0] cause;
  always_comb begin
    if (!req_prot)     cause = C_NONE;
    else if (is_null)  cause = C_NULL;
    else if (!in_range) cause = C_RANGE;
    else if (over)     cause = C_LIMIT;
    else               cause = C_NONE;
  end

  wire accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_ok    <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= C_NONE;
      rsp_rpl   <= 2'd0;
    end else begin
      req_ready <= 1'b1;
      rsp_valid <= accept;
      if (accept) begin
        rsp_cause <= cause;
        rsp_fault <= cause != C_NONE;
        rsp_ok    <= cause == C_NONE;
        rsp_rpl   <= req_prot ? req_seg[1:0] : 2'd0;
        if (cause != C_NONE) rsp_addr <= '0;
        else if (!req_prot)  rsp_addr <= {12'h000, real_sum};
        else                 rsp_addr <= prot_sum;
      end
    end
  end

  // R8
  a_r8_one_cycle_latency: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> rsp_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !rsp_valid);
  // R1
  a_r1_real_no_fault: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !req_prot |=> !rsp_fault && rsp_addr[31:20] == 12'h000);
  // R3
  a_r3_null_fault: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && req_prot && req_seg[15:2] == 14'd0 |=> rsp_fault && rsp_cause == 2'd1);
  // R7
  a_r7_fault_kills_addr: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> !rsp_ok && rsp_addr == 32'd0 && rsp_cause != 2'd0);
endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 0, rst = 1;
  logic wr_en = 0, wr_local = 0, wr_gran = 0;
  logic [IW-1:0] wr_idx = '0;
  logic [31:0] wr_base = '0;
  logic [19:0] wr_limit = '0;
  logic req_valid = 0, req_prot = 0;
  logic [15:0] req_seg = '0;
  logic [31:0] req_off = '0;
  logic req_ready, rsp_valid, rsp_ok, rsp_fault;
  logic [31:0] rsp_addr;
  logic [1:0] rsp_cause, rsp_rpl;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  seg_xlate #(.DESC_PER_TABLE(N)) u_dut (
    .clk, .rst, .wr_en, .wr_local, .wr_idx, .wr_base, .wr_limit, .wr_gran,
    .req_valid, .req_ready, .req_prot, .req_seg, .req_off,
    .rsp_valid, .rsp_addr, .rsp_ok, .rsp_fault, .rsp_cause, .rsp_rpl);

  // {prot, seg, off, ok, cause, addr, rpl}
  localparam int NV = 16;
  localparam logic [85:0] VEC [NV] = '{
    {1'b0, 16'h2000, 32'h0000_1234, 1'b1, 2'd0, 32'h0002_1234, 2'd0}, // R1
    {1'b0, 16'hFFFF, 32'h0000_FFFF, 1'b1, 2'd0, 32'h0000_FFEF, 2'd0}, // R1 wrap
    {1'b0, 16'h1003, 32'hABCD_0010, 1'b1, 2'd0, 32'h0001_0040, 2'd0}, // R1 upper ignored
    {1'b1, 16'h0008, 32'h0000_0000, 1'b1, 2'd0, 32'h0010_0000, 2'd0}, // R2 R7
    {1'b1, 16'h0008, 32'h0000_00FF, 1'b1, 2'd0, 32'h0010_00FF, 2'd0}, // R5 at limit
    {1'b1, 16'h0008, 32'h0000_0100, 1'b0, 2'd3, 32'h0000_0000, 2'd0}, // R5 over
    {1'b1, 16'h0010, 32'h0000_01FF, 1'b1, 2'd0, 32'h1000_01FF, 2'd0}, // R5
    {1'b1, 16'h0010, 32'h0000_0200, 1'b0, 2'd3, 32'h0000_0000, 2'd0}, // R5
    {1'b1, 16'h0018, 32'h001F_FFFF, 1'b1, 2'd0, 32'h101F_FFFF, 2'd0}, // R6 at limit
    {1'b1, 16'h0018, 32'h0020_0000, 1'b0, 2'd3, 32'h0000_0000, 2'd0}, // R6 over
    {1'b1, 16'h0000, 32'h0000_0000, 1'b0, 2'd1, 32'h0000_0000, 2'd0}, // R3
    {1'b1, 16'h0003, 32'h0000_0010, 1'b0, 2'd1, 32'h0000_0000, 2'd3}, // R3 with rpl
    {1'b1, 16'h0004, 32'h1234_5678, 1'b1, 2'd0, 32'h1274_5678, 2'd0}, // R3 local 0 legal
    {1'b1, 16'h0006, 32'hFFF0_0000, 1'b1, 2'd0, 32'h0030_0000, 2'd2}, // R7 wrap
    {1'b1, 16'h0040, 32'h0000_0000, 1'b0, 2'd2, 32'h0000_0000, 2'd0}, // R4
    {1'b1, 16'h000B, 32'h0000_0010, 1'b1, 2'd0, 32'h0010_0010, 2'd3}  // R2 rpl
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic loc, input logic [IW-1:0] idx, input logic [31:0] b,
                    input logic [19:0] l, input logic g);
    @(negedge clk);
    wr_en = 1; wr_local = loc; wr_idx = idx; wr_base = b; wr_limit = l; wr_gran = g;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic req(input logic p, input logic [15:0] s, input logic [31:0] o);
    @(negedge clk);
    req_valid = 1; req_prot = p; req_seg = s; req_off = o;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 ready in reset", {31'd0, req_ready}, 32'd0);
    chk("R10 valid in reset", {31'd0, rsp_valid}, 32'd0);
    rst = 0;
    @(negedge clk);
    chk("R10 ready after reset", {31'd0, req_ready}, 32'd1);
    req(1'b1, 16'h0020, 32'h0);
    chk("R10 cleared entry addr", rsp_addr, 32'd0);
    chk("R10 cleared entry ok", {31'd0, rsp_ok}, 32'd1);
    req(1'b1, 16'h0020, 32'h1);
    chk("R10 cleared entry limit", {30'd0, rsp_cause}, 32'd3);

    wr(1'b0, 3'd1, 32'h0010_0000, 20'h000FF, 1'b0);
    wr(1'b0, 3'd2, 32'h1000_0000, 20'h001FF, 1'b0);
    wr(1'b0, 3'd3, 32'h1000_0000, 20'h001FF, 1'b1);
    wr(1'b1, 3'd0, 32'h0040_0000, 20'hFFFFF, 1'b1);

    for (int i = 0; i < NV; i++) begin
      logic [85:0] v;
      v = VEC[i];
      req(v[85], v[84:69], v[68:37]);
      chk($sformatf("R8 valid vec %0d", i), {31'd0, rsp_valid}, 32'd1);
      chk($sformatf("R1-7 ok vec %0d", i), {31'd0, rsp_ok}, {31'd0, v[36]});
      chk($sformatf("R3/R4/R5 cause vec %0d", i), {30'd0, rsp_cause}, {30'd0, v[35:34]});
      chk($sformatf("R7 fault vec %0d", i), {31'd0, rsp_fault}, {31'd0, v[35:34] != 2'd0});
      chk($sformatf("R1/R7 addr vec %0d", i), rsp_addr, v[33:2]);
      chk($sformatf("R2 rpl vec %0d", i), {30'd0, rsp_rpl}, {30'd0, v[1:0]});
    end

    @(negedge clk);
    chk("R8 valid drops", {31'd0, rsp_valid}, 32'd0);

    // R9: same-cycle write sees old entry, later request sees new
    @(negedge clk);
    wr_en = 1; wr_local = 0; wr_idx = 3'd1; wr_base = 32'h0020_0000; wr_limit = 20'h000FF; wr_gran = 0;
    req_valid = 1; req_prot = 1; req_seg = 16'h0008; req_off = 32'h10;
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    chk("R9 same cycle old base", rsp_addr, 32'h0010_0010);
    req(1'b1, 16'h0008, 32'h10);
    chk("R9 new base", rsp_addr, 32'h0020_0010);
    req(1'b1, 16'h000C, 32'h10);
    chk("R9 local table untouched", {30'd0, rsp_cause}, 32'd3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule